// File: doc/BRIEF.md
# Instruction Fetch Slot Sequencer

This block sits between the machine-cycle timing generator and the program-counter and instruction registers of a small 8-bit controller. Every machine cycle offers two code-fetch slots, one per address-latch pulse. The sequencer decides, slot by slot, whether the byte on the code bus is a real fetch or a dummy read. A real fetch is captured as an opcode or as an operand and advances the program counter. A dummy read re-reads the same address and leaves the counter alone.

The instruction class comes from an external decode table. It is sampled only in the opcode slot and held for the rest of the instruction. It fixes the number of code bytes (1 to 3) and the number of machine cycles (1, 2 or 4). One class marks an external-data transfer. Its first machine cycle has a valid opcode fetch and a dummy fetch. Its second machine cycle has no code fetch at all and raises a data-cycle request instead. The block pulses instruction-done at the end of the last machine cycle, and the next slot is then treated as a new opcode slot.

Top module: `fetch_slot_seq`

## Requirements
- R1: Class codes on `iclass_i` map to bytes/cycles as follows: 0 = 1/1, 1 = 1/2, 2 = 2/1, 3 = 2/2, 4 = 3/2, 5 = 1/4, 6 = external-data 1/2. Over one instruction, `pc_inc_o` pulses exactly once per code byte.
- R2: In the first slot of an instruction, `op_cap_o` and `pc_inc_o` are high in the strobe cycle. From the next clock, `opcode_o` holds the byte that was on `code_byte_i`.
- R3: Slot k of an instruction, for 1 ≤ k < bytes, raises `arg_cap_o` and `pc_inc_o` with `arg_idx_o` = k−1. From the next clock, `args_o[8*(k-1) +: 8]` holds the byte that was on `code_byte_i`.
- R4: Every later slot, counted from zero, is a dummy read: `dummy_o` is high, and `pc_inc_o`, `op_cap_o` and `arg_cap_o` stay low.
- R5: For class 6, slot 0 is the opcode fetch and slot 1 is a dummy. Through the whole second machine cycle, `xdata_req_o` is high, and its strobes raise none of `pc_inc_o`, `op_cap_o`, `arg_cap_o` or `dummy_o`.
- R6: `instr_done_o` is high only in the `mc_end_i` cycle that closes the class's last machine cycle. The next strobe is an opcode slot.
- R7: After reset, all pulse outputs are low, captured bytes are zero, and an `mc_end_i` before any strobe gives no done. The first strobe is an opcode slot.
- R8: `iclass_i` is ignored in every slot except the opcode slot.
- R9: Reserved class 7 behaves as 1 byte / 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_strb_i | input | 1 | One-clock strobe marking a fetch slot |
| mc_end_i | input | 1 | One-clock strobe closing a machine cycle |
| code_byte_i | input | 8 | Byte on the code bus during the slot |
| iclass_i | input | 3 | Class code from the decode table |
| pc_inc_o | output | 1 | Advance the program counter |
| op_cap_o | output | 1 | Capture byte as opcode |
| arg_cap_o | output | 1 | Capture byte as operand |
| arg_idx_o | output | 1 | Operand index for the capture |
| dummy_o | output | 1 | Slot is a dummy re-read |
| xdata_req_o | output | 1 | External data cycle in progress |
| instr_done_o | output | 1 | Instruction complete |
| opcode_o | output | 8 | Captured opcode |
| args_o | output | 16 | Captured operands, operand 0 in the low byte |

## Verification
The slot enables (`pc_inc_o`, `op_cap_o`, `arg_cap_o`, `arg_idx_o`, `dummy_o`) are combinational on the strobe, so they are due in the strobe cycle itself. `instr_done_o` is likewise due in the `mc_end_i` cycle. The captured bytes are registered and appear one clock after the strobe. The bench drives every input at the falling edge. It samples the combinational results 1 ns later, inside the same cycle, and samples the registered bytes 1 ns after the following rising edge. The expected values come from a per-class table of byte counts and cycle counts kept in the bench.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  localparam int MAX_MC  = 4;
  localparam int SLOT_W  = $clog2(2 * MAX_MC + 1);
  localparam int CLS_W   = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_B1M1 = 3'd0,
    CLS_B1M2 = 3'd1,
    CLS_B2M1 = 3'd2,
    CLS_B2M2 = 3'd3,
    CLS_B3M2 = 3'd4,
    CLS_B1M4 = 3'd5,
    CLS_XMEM = 3'd6,
    CLS_RSVD = 3'd7
  } iclass_e;

  function automatic logic [SLOT_W-1:0] cls_bytes(input logic [CLS_W-1:0] c);
    case (iclass_e'(c))
      CLS_B2M1, CLS_B2M2: cls_bytes = SLOT_W'(2);
      CLS_B3M2:           cls_bytes = SLOT_W'(3);
      default:            cls_bytes = SLOT_W'(1);
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] cls_cycles(input logic [CLS_W-1:0] c);
    case (iclass_e'(c))
      CLS_B1M2, CLS_B2M2, CLS_B3M2, CLS_XMEM: cls_cycles = SLOT_W'(2);
      CLS_B1M4:                               cls_cycles = SLOT_W'(MAX_MC);
      default:                                cls_cycles = SLOT_W'(1);
    endcase
  endfunction

  function automatic logic cls_is_xmem(input logic [CLS_W-1:0] c);
    cls_is_xmem = (iclass_e'(c) == CLS_XMEM);
  endfunction
endpackage

// File: rtl/fsq_slot_ctr.sv
module fsq_slot_ctr
  import fsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb,
  input  logic              done,
  input  logic [CLS_W-1:0]  cls_now,
  output logic [SLOT_W-1:0] slot_q,
  output logic [CLS_W-1:0]  cls_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      cls_q  <= '0;
    end else if (done) begin
      slot_q <= '0;
    end else if (strb) begin
      slot_q <= slot_q + SLOT_W'(1);
      if (slot_q == '0) cls_q <= cls_now;
    end
  end
endmodule

// File: rtl/fsq_slot_decode.sv
module fsq_slot_decode
  import fsq_pkg::*;
#(
  parameter int ARG_W = 1
) (
  input  logic              strb,
  input  logic              mc_end,
  input  logic [SLOT_W-1:0] slot_q,
  input  logic [CLS_W-1:0]  cls_in,
  input  logic [CLS_W-1:0]  cls_q,
  output logic [CLS_W-1:0]  cls_now,
  output logic              pc_inc,
  output logic              op_cap,
  output logic              arg_cap,
  output logic [ARG_W-1:0]  arg_idx,
  output logic              dummy,
  output logic              xreq,
  output logic              done
);
  localparam logic [SLOT_W-1:0] SECOND_MC = SLOT_W'(2);

  logic              first_slot;
  logic [SLOT_W-1:0] nbytes;
  logic [SLOT_W-1:0] nslots;
  logic              real_fetch;

  always_comb begin
    first_slot = (slot_q == '0);
    cls_now    = first_slot ? cls_in : cls_q;
    nbytes     = cls_bytes(cls_now);
    nslots     = cls_cycles(cls_q) << 1;
    xreq       = !first_slot && cls_is_xmem(cls_q) && (slot_q >= SECOND_MC);
    real_fetch = strb && !xreq && (slot_q < nbytes);
    op_cap     = real_fetch && first_slot;
    arg_cap    = real_fetch && !first_slot;
    pc_inc     = real_fetch;
    arg_idx    = ARG_W'(slot_q - SLOT_W'(1));
    dummy      = strb && !xreq && !real_fetch;
    done       = mc_end && !first_slot && (slot_q == nslots);
  end
endmodule

// File: rtl/fsq_capture.sv
module fsq_capture #(
  parameter int BYTE_W   = 8,
  parameter int NUM_ARGS = 2,
  parameter int ARG_W    = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       op_cap,
  input  logic                       arg_cap,
  input  logic [ARG_W-1:0]           arg_idx,
  input  logic [BYTE_W-1:0]          byte_in,
  output logic [BYTE_W-1:0]          opcode_q,
  output logic [NUM_ARGS*BYTE_W-1:0] args_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      opcode_q <= '0;
    else if (op_cap) opcode_q <= byte_in;
  end

  for (genvar g = 0; g < NUM_ARGS; g++) begin : g_arg
    always_ff @(posedge clk) begin
      if (!rst_n)
        args_q[g*BYTE_W +: BYTE_W] <= '0;
      else if (arg_cap && (arg_idx == ARG_W'(g)))
        args_q[g*BYTE_W +: BYTE_W] <= byte_in;
    end
  end
endmodule

// File: rtl/fetch_slot_seq.sv
module fetch_slot_seq
  import fsq_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int NUM_ARGS = 2,
  localparam int ARG_W   = (NUM_ARGS > 1) ? $clog2(NUM_ARGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fetch_strb_i,
  input  logic                       mc_end_i,
  input  logic [BYTE_W-1:0]          code_byte_i,
  input  logic [CLS_W-1:0]           iclass_i,
  output logic                       pc_inc_o,
  output logic                       op_cap_o,
  output logic                       arg_cap_o,
  output logic [ARG_W-1:0]           arg_idx_o,
  output logic                       dummy_o,
  output logic                       xdata_req_o,
  output logic                       instr_done_o,
  output logic [BYTE_W-1:0]          opcode_o,
  output logic [NUM_ARGS*BYTE_W-1:0] args_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [CLS_W-1:0]  cls_q;
  logic [CLS_W-1:0]  cls_now;
  logic              slot_zero;

  assign slot_zero = (slot_q == '0);

  fsq_slot_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (fetch_strb_i),
    .done    (instr_done_o),
    .cls_now (cls_now),
    .slot_q  (slot_q),
    .cls_q   (cls_q)
  );

  fsq_slot_decode #(.ARG_W(ARG_W)) u_dec (
    .strb    (fetch_strb_i),
    .mc_end  (mc_end_i),
    .slot_q  (slot_q),
    .cls_in  (iclass_i),
    .cls_q   (cls_q),
    .cls_now (cls_now),
    .pc_inc  (pc_inc_o),
    .op_cap  (op_cap_o),
    .arg_cap (arg_cap_o),
    .arg_idx (arg_idx_o),
    .dummy   (dummy_o),
    .xreq    (xdata_req_o),
    .done    (instr_done_o)
  );

  fsq_capture #(.BYTE_W(BYTE_W), .NUM_ARGS(NUM_ARGS), .ARG_W(ARG_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_cap   (op_cap_o),
    .arg_cap  (arg_cap_o),
    .arg_idx  (arg_idx_o),
    .byte_in  (code_byte_i),
    .opcode_q (opcode_o),
    .args_q   (args_o)
  );
endmodule

// File: rtl/fsq_checker.sv
module fsq_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mc_end_i,
  input logic [BYTE_W-1:0] code_byte_i,
  input logic              pc_inc_o,
  input logic              op_cap_o,
  input logic              arg_cap_o,
  input logic              dummy_o,
  input logic              xdata_req_o,
  input logic              instr_done_o,
  input logic [BYTE_W-1:0] opcode_o,
  input logic              slot_zero
);
  // R2
  op_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_cap_o |-> pc_inc_o);

  // R2
  op_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_cap_o |=> (opcode_o == $past(code_byte_i)));

  // R3
  one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_cap_o, arg_cap_o, dummy_o}));

  // R4
  dummy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_o |-> (!pc_inc_o && !op_cap_o && !arg_cap_o));

  // R5
  xmem_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xdata_req_o |-> (!pc_inc_o && !dummy_o && !op_cap_o && !arg_cap_o));

  // R6
  done_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done_o |-> mc_end_i);

  // R6
  done_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done_o |=> slot_zero);
endmodule

bind fetch_slot_seq fsq_checker #(.BYTE_W(BYTE_W)) u_fsq_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mc_end_i     (mc_end_i),
  .code_byte_i  (code_byte_i),
  .pc_inc_o     (pc_inc_o),
  .op_cap_o     (op_cap_o),
  .arg_cap_o    (arg_cap_o),
  .dummy_o      (dummy_o),
  .xdata_req_o  (xdata_req_o),
  .instr_done_o (instr_done_o),
  .opcode_o     (opcode_o),
  .slot_zero    (slot_zero)
);

// File: tb/fetch_slot_seq_test.sv
module fetch_slot_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_strb_i = 1'b0;
  logic        mc_end_i = 1'b0;
  logic [7:0]  code_byte_i = '0;
  logic [2:0]  iclass_i = '0;
  logic        pc_inc_o, op_cap_o, arg_cap_o, dummy_o, xdata_req_o, instr_done_o;
  logic [0:0]  arg_idx_o;
  logic [7:0]  opcode_o;
  logic [15:0] args_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int model_k = 0;
  int model_cls = 0;
  int pc_count = 0;
  int nb [8] = '{1, 1, 2, 2, 3, 1, 1, 1};
  int nc [8] = '{1, 2, 1, 2, 2, 4, 2, 1};

  always #2 clk = ~clk;

  fetch_slot_seq uut (
    .clk(clk), .rst_n(rst_n), .fetch_strb_i(fetch_strb_i), .mc_end_i(mc_end_i),
    .code_byte_i(code_byte_i), .iclass_i(iclass_i), .pc_inc_o(pc_inc_o),
    .op_cap_o(op_cap_o), .arg_cap_o(arg_cap_o), .arg_idx_o(arg_idx_o),
    .dummy_o(dummy_o), .xdata_req_o(xdata_req_o), .instr_done_o(instr_done_o),
    .opcode_o(opcode_o), .args_o(args_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    fetch_strb_i = 1'b0;
    mc_end_i = 1'b0;
  endtask

  task automatic do_slot(input logic [7:0] b, input logic [2:0] cin);
    int c, e_pc, e_op, e_arg, e_dm, e_x, e_idx;
    string rq;
    c = (model_k == 0) ? int'(cin) : model_cls;
    e_x = (c == 6 && model_k >= 2) ? 1 : 0;
    e_op = (model_k == 0) ? 1 : 0;
    e_arg = (model_k != 0 && e_x == 0 && model_k < nb[c]) ? 1 : 0;
    e_pc = e_op | e_arg;
    e_dm = (e_pc == 0 && e_x == 0) ? 1 : 0;
    e_idx = model_k - 1;
    rq = (model_k != 0 && int'(cin) != model_cls) ? "R8" : (e_x != 0) ? "R5" :
         (e_dm != 0) ? "R4" : (e_op != 0) ? "R2" : "R3";
    @(negedge clk);
    fetch_strb_i = 1'b1;
    code_byte_i = b;
    iclass_i = cin;
    #1;
    chk(pc_inc_o == e_pc, $sformatf("%s pc_inc cls%0d slot%0d", rq, c, model_k), pc_inc_o, e_pc);
    chk(op_cap_o == e_op, $sformatf("%s op_cap cls%0d slot%0d", rq, c, model_k), op_cap_o, e_op);
    chk(arg_cap_o == e_arg, $sformatf("%s arg_cap cls%0d slot%0d", rq, c, model_k), arg_cap_o, e_arg);
    chk(dummy_o == e_dm, $sformatf("%s dummy cls%0d slot%0d", rq, c, model_k), dummy_o, e_dm);
    chk(xdata_req_o == e_x, $sformatf("R5 xdata cls%0d slot%0d", c, model_k), xdata_req_o, e_x);
    if (e_arg != 0)
      chk(int'(arg_idx_o) == e_idx, "R3 arg_idx", int'(arg_idx_o), e_idx);
    if (pc_inc_o) pc_count++;
    @(posedge clk);
    #1;
    fetch_strb_i = 1'b0;
    if (e_op != 0) chk(opcode_o == b, "R2 opcode_o", opcode_o, b);
    if (e_arg != 0)
      chk(args_o[8*e_idx +: 8] == b, "R3 args_o", args_o[8*e_idx +: 8], b);
    if (model_k == 0) model_cls = c;
    model_k++;
  endtask

  task automatic do_mcend();
    int e_done, e_x;
    string rq;
    e_done = (model_k != 0 && model_k == 2 * nc[model_cls]) ? 1 : 0;
    e_x = (model_k >= 2 && model_cls == 6) ? 1 : 0;
    rq = (model_k == 0) ? "R7" : (model_cls == 7) ? "R9" : "R6";
    @(negedge clk);
    mc_end_i = 1'b1;
    #1;
    chk(instr_done_o == e_done, $sformatf("%s done cls%0d k%0d", rq, model_cls, model_k),
        instr_done_o, e_done);
    chk(xdata_req_o == e_x, "R5 xdata at mc_end", xdata_req_o, e_x);
    @(posedge clk);
    #1;
    mc_end_i = 1'b0;
    if (e_done != 0) model_k = 0;
  endtask

  task automatic run_instr(input int c, input bit noise);
    logic [2:0] cin;
    pc_count = 0;
    for (int m = 0; m < nc[c]; m++) begin
      for (int s = 0; s < 2; s++) begin
        cin = (m == 0 && s == 0) ? 3'(c) : (noise ? 3'(c ^ 5) : 3'(c));
        do_slot(8'(8'h81 + 16 * c + 2 * m + s + (noise ? 8'h40 : 8'h00)), cin);
        idle();
      end
      do_mcend();
    end
    chk(pc_count == nb[c], $sformatf("R1 pc_inc count cls%0d", c), pc_count, nb[c]);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk({pc_inc_o, op_cap_o, arg_cap_o, dummy_o, xdata_req_o, instr_done_o} == 6'b0,
        "R7 reset pulses", 0, 0);
    chk(opcode_o == 8'h00, "R7 reset opcode", opcode_o, 0);
    chk(args_o == 16'h0000, "R7 reset args", args_o, 0);
    do_mcend();
    for (int rep = 0; rep < 2; rep++)
      for (int c = 0; c < 8; c++)
        run_instr(c, rep == 1);
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        run_instr(a, 1'b0);
        run_instr(b, 1'b1);
      end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule